// File: doc/BRIEF.md
# Smart Card Interface Fault Supervisor

This block watches the digitised fault indications around a smart card power path and decides when the power sequencer must run an emergency power-down of the card. It takes comparator flags for two supply-droop thresholds, regulator over-current, die over-temperature and card withdrawal. A strap picks which supply threshold is in force. The host's activation command is also an input, and the sequencer reports power-up completion and idleness.

Each source has its own qualification. The low supply threshold, over-temperature and card withdrawal act at once. The high supply threshold must persist for a parameterised number of internal clock cycles. Over-current seen while power-up is still running is held and acted on when power-up completes. Over-current seen on a powered card must persist for its own window. Each qualified fault raises one power-down request to the sequencer, and that request is held until the sequencer reports idle. Supply and over-current faults also pull an active-low flag to the host. The flag stays low until the host command shows a rising edge.

All flag inputs and the host command pass through a synchroniser of `SYNC_STAGES` flops before any decision is made. Sequencer status inputs are taken as already synchronous.

Top module: `cif_fault_supervisor`

## Requirements
- R1: While reset is asserted and after its release with quiet inputs, `pdn_req_o` is 0 and `fault_n_o` is 1.
- R2: With `thr_sel_i` = 1, asserting `uv_lo_i` sets `pdn_req_o` to 1 and `fault_n_o` to 0 on the (SYNC_STAGES+1)-th rising edge after it is driven. `uv_hi_i` alone then causes no request.
- R3: With `thr_sel_i` = 0, `uv_hi_i` must be sampled high on UV_WIN consecutive cycles after synchronisation. The request and the flag then appear on edge SYNC_STAGES+UV_WIN. A shorter pulse restarts the count and produces nothing, and `uv_lo_i` alone produces nothing.
- R4: Once low, `fault_n_o` stays low until a rising edge of `host_cmd_i`. It returns to 1 on the (SYNC_STAGES+1)-th edge after that rising edge, and a falling edge has no effect. A new supply or over-current fault in the same cycle as the rising edge keeps the flag low.
- R5: Over-current seen while power-up is in progress (`pwrup_done_i` = 0, `seq_idle_i` = 0) is remembered. It raises the request on the first edge at which `pwrup_done_i` is 1. A remembered event is discarded if `seq_idle_i` goes to 1 first.
- R6: With `pwrup_done_i` = 1, `oc_i` must be sampled high on OC_WIN consecutive synchronised cycles. The request appears on edge SYNC_STAGES+OC_WIN, and a shorter pulse produces nothing.
- R7: A qualified over-current drives `fault_n_o` to 0 together with the request.
- R8: `temp_i` or `card_out_i` raises `pdn_req_o` on the (SYNC_STAGES+1)-th edge without filtering, and leaves `fault_n_o` at 1.
- R9: `pdn_req_o` is held while `seq_idle_i` is 0 and clears on the edge at which `seq_idle_i` is 1 with no new fault. Each assertion of a source yields one request, so a source that stays high does not re-raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal fixed clock timing all windows |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uv_lo_i | input | 1 | Supply below low threshold |
| uv_hi_i | input | 1 | Supply below high threshold |
| oc_i | input | 1 | Regulator over-current |
| temp_i | input | 1 | Over-temperature |
| card_out_i | input | 1 | Card withdrawn |
| thr_sel_i | input | 1 | 1: low threshold, immediate; 0: high threshold, filtered |
| host_cmd_i | input | 1 | Host activation command; rising edge clears the flag |
| pwrup_done_i | input | 1 | Sequencer has completed power-up |
| seq_idle_i | input | 1 | Sequencer is idle (card powered down) |
| pdn_req_o | output | 1 | Emergency power-down request to the sequencer |
| fault_n_o | output | 1 | Latched active-low fault flag to the host |

## Verification
The bench builds the block with SYNC_STAGES = 2, UV_WIN = 6 and OC_WIN = 4. These short windows let it place a pulse exactly one cycle short of each filter and then one that just qualifies, and it checks the output on the edge before and on the edge of the expected change. The small values also leave cycles to cover both branches of the over-current timing, to discard a held event when the sequencer goes idle, and to line up a host rising edge against a new fault in the same cycle.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  // Bit positions inside the vector passed through the input synchroniser
  localparam int unsigned SI_UVLO = 0;
  localparam int unsigned SI_UVHI = 1;
  localparam int unsigned SI_OC   = 2;
  localparam int unsigned SI_TEMP = 3;
  localparam int unsigned SI_CARD = 4;
  localparam int unsigned SI_SEL  = 5;
  localparam int unsigned SI_HCMD = 6;
  localparam int unsigned SI_W    = 7;

  // Unfiltered channels (one pulse per assertion)
  typedef enum logic [1:0] {
    IMM_UVLO = 2'd0,
    IMM_TEMP = 2'd1,
    IMM_CARD = 2'd2
  } imm_ch_e;
  localparam int unsigned IMM_N = 3;

  // Qualified fault events, one cycle wide
  typedef struct packed {
    logic uv;
    logic oc;
    logic temp;
    logic card;
  } cfs_evt_t;

endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/cfs_sync.sv
module cfs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/cfs_persist.sv
// Persistence filter: hit pulses once when lvl_i has been sampled high on
// WIN consecutive cycles while arm_i is high; any gap restarts the count.
module cfs_persist #(
  parameter int unsigned WIN = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic lvl_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(WIN);
  localparam logic [CW-1:0] CNT_LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (!(arm_i && lvl_i)) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_d = cnt_q + 1'b1;
      hit_o = (cnt_q == CNT_LAST);
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfs_oc_qual.sv
// Over-current qualification: held during power-up, filtered afterwards.
module cfs_oc_qual #(
  parameter int unsigned OC_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic pwrup_done_i,
  input  logic seq_idle_i,
  output logic evt_o
);

  logic held_q, held_d;
  logic late_hit, filt_hit;

  assign late_hit = held_q && pwrup_done_i;

  cfs_persist #(.WIN(OC_WIN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (pwrup_done_i),
    .lvl_i  (oc_i),
    .hit_o  (filt_hit)
  );

  assign evt_o = late_hit || filt_hit;

  always_comb begin
    held_d = held_q;
    if (seq_idle_i || late_hit)  held_d = 1'b0;
    else if (oc_i && !pwrup_done_i) held_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= held_d;
  end

endmodule

// File: rtl/cif_fault_supervisor.sv
module cif_fault_supervisor
  import cfs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned UV_WIN      = 50,
  parameter int unsigned OC_WIN      = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_lo_i,
  input  logic uv_hi_i,
  input  logic oc_i,
  input  logic temp_i,
  input  logic card_out_i,
  input  logic thr_sel_i,
  input  logic host_cmd_i,
  input  logic pwrup_done_i,
  input  logic seq_idle_i,
  output logic pdn_req_o,
  output logic fault_n_o
);

  logic            rst_n;
  logic [SI_W-1:0] raw_v, syn_v;
  logic [IMM_N-1:0] imm_arm, imm_lvl, imm_hit;
  logic            uvhi_hit;
  logic            oc_evt;
  logic            flag_evt;
  logic            hcmd_prev_q;
  logic            hcmd_rise;
  cfs_evt_t        evt;
  logic            req_q, req_d;
  logic            flag_q, flag_d;

  cfs_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  always_comb begin
    raw_v          = '0;
    raw_v[SI_UVLO] = uv_lo_i;
    raw_v[SI_UVHI] = uv_hi_i;
    raw_v[SI_OC]   = oc_i;
    raw_v[SI_TEMP] = temp_i;
    raw_v[SI_CARD] = card_out_i;
    raw_v[SI_SEL]  = thr_sel_i;
    raw_v[SI_HCMD] = host_cmd_i;
  end

  cfs_sync #(.W(SI_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (raw_v),
    .sync_o  (syn_v)
  );

  // Unfiltered channels
  always_comb begin
    imm_arm           = '1;
    imm_lvl           = '0;
    imm_arm[IMM_UVLO] = syn_v[SI_SEL];
    imm_lvl[IMM_UVLO] = syn_v[SI_UVLO];
    imm_lvl[IMM_TEMP] = syn_v[SI_TEMP];
    imm_lvl[IMM_CARD] = syn_v[SI_CARD];
  end

  for (genvar c = 0; c < IMM_N; c++) begin : g_imm
    cfs_persist #(.WIN(1)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .arm_i  (imm_arm[c]),
      .lvl_i  (imm_lvl[c]),
      .hit_o  (imm_hit[c])
    );
  end

  // High supply threshold, filtered
  cfs_persist #(.WIN(UV_WIN)) u_uvhi (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .arm_i  (!syn_v[SI_SEL]),
    .lvl_i  (syn_v[SI_UVHI]),
    .hit_o  (uvhi_hit)
  );

  cfs_oc_qual #(.OC_WIN(OC_WIN)) u_oc (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .oc_i         (syn_v[SI_OC]),
    .pwrup_done_i (pwrup_done_i),
    .seq_idle_i   (seq_idle_i),
    .evt_o        (oc_evt)
  );

  always_comb begin
    evt.uv   = imm_hit[IMM_UVLO] || uvhi_hit;
    evt.oc   = oc_evt;
    evt.temp = imm_hit[IMM_TEMP];
    evt.card = imm_hit[IMM_CARD];
  end

  assign flag_evt  = evt.uv || evt.oc;
  assign hcmd_rise = syn_v[SI_HCMD] && !hcmd_prev_q;

  // Next state: new faults take priority over clearing
  always_comb begin
    req_d = req_q;
    if (|evt)           req_d = 1'b1;
    else if (seq_idle_i) req_d = 1'b0;

    flag_d = flag_q;
    if (flag_evt)       flag_d = 1'b1;
    else if (hcmd_rise) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      flag_q      <= 1'b0;
      hcmd_prev_q <= 1'b0;
    end else begin
      req_q       <= req_d;
      flag_q      <= flag_d;
      hcmd_prev_q <= syn_v[SI_HCMD];
    end
  end

  assign pdn_req_o = req_q;
  assign fault_n_o = !flag_q;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic seq_idle_i,
  input logic pwrup_done_i,
  input logic pdn_req_o,
  input logic fault_n_o,
  input logic hcmd_rise,
  input logic oc_evt
);

  // R1: quiet outputs while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!pdn_req_o && fault_n_o));

  // R9: request held while the sequencer is busy
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_req_o && !seq_idle_i) |=> pdn_req_o);

  // R9: request only drops after idle was reported
  a_r9_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pdn_req_o) |-> $past(seq_idle_i));

  // R4: flag only released after a host rising edge
  a_r4_flag_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_n_o) |-> $past(hcmd_rise));

  // R7: a flag fall always comes with a power-down request
  a_r7_flag_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_n_o) |-> pdn_req_o);

  // R5: over-current never acted on before power-up completes
  a_r5_oc_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_evt |-> pwrup_done_i);

endmodule

bind cif_fault_supervisor cfs_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n),
  .seq_idle_i   (seq_idle_i),
  .pwrup_done_i (pwrup_done_i),
  .pdn_req_o    (pdn_req_o),
  .fault_n_o    (fault_n_o),
  .hcmd_rise    (hcmd_rise),
  .oc_evt       (oc_evt)
);

// File: tb/cif_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module cif_fault_supervisor_tb_top;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned UV_WIN      = 6;
  localparam int unsigned OC_WIN      = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic uv_lo, uv_hi, oc, temp, card_out, thr_sel, host_cmd, pwrup_done, seq_idle;
  logic pdn_req, fault_n;

  always #10 clk = ~clk;

  cif_fault_supervisor #(
    .SYNC_STAGES (SYNC_STAGES),
    .UV_WIN      (UV_WIN),
    .OC_WIN      (OC_WIN)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .uv_lo_i      (uv_lo),
    .uv_hi_i      (uv_hi),
    .oc_i         (oc),
    .temp_i       (temp),
    .card_out_i   (card_out),
    .thr_sel_i    (thr_sel),
    .host_cmd_i   (host_cmd),
    .pwrup_done_i (pwrup_done),
    .seq_idle_i   (seq_idle),
    .pdn_req_o    (pdn_req),
    .fault_n_o    (fault_n)
  );

  typedef struct {
    string tag;
    bit    pdn;
    bit    flt;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // Monitor: compares every queued expectation away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pdn_req !== e.pdn || fault_n !== e.flt) begin
        errors++;
        $display("FAIL %s: actual pdn_req=%b fault_n=%b expected pdn_req=%b fault_n=%b",
                 e.tag, pdn_req, fault_n, e.pdn, e.flt);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, bit pdn, bit flt);
    exp_t e;
    e.tag = tag;
    e.pdn = pdn;
    e.flt = flt;
    q.push_back(e);
  endtask

  task automatic host_pulse();
    host_cmd = 1'b0;
    tick(3);
    host_cmd = 1'b1;
    tick(3);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual run still busy expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv_lo = 1'b0; uv_hi = 1'b0; oc = 1'b0; temp = 1'b0;
    card_out = 1'b0; thr_sel = 1'b1; host_cmd = 1'b1;
    pwrup_done = 1'b0; seq_idle = 1'b1;
    tick(3);
    expect_out("R1 in reset", 1'b0, 1'b1);
    rst_n = 1'b1;
    tick(6);
    expect_out("R1 after release", 1'b0, 1'b1);

    // Low threshold, immediate; hold and release of request and flag
    seq_idle = 1'b0;
    uv_lo = 1'b1;
    tick(2);
    expect_out("R2 before latency", 1'b0, 1'b1);
    tick(1);
    expect_out("R2 low threshold trip", 1'b1, 1'b0);
    uv_lo = 1'b0;
    tick(4);
    expect_out("R9 held while busy", 1'b1, 1'b0);
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 cleared by idle, R4 flag kept", 1'b0, 1'b0);
    host_cmd = 1'b0;
    tick(4);
    expect_out("R4 falling edge no clear", 1'b0, 1'b0);
    host_cmd = 1'b1;
    tick(2);
    expect_out("R4 before clear latency", 1'b0, 1'b0);
    tick(1);
    expect_out("R4 rising edge clears", 1'b0, 1'b1);

    // High threshold ignored when the low threshold is selected
    seq_idle = 1'b0;
    uv_hi = 1'b1;
    tick(12);
    expect_out("R2 high threshold ignored", 1'b0, 1'b1);
    uv_hi = 1'b0;
    tick(3);

    // High threshold, filtered
    thr_sel = 1'b0;
    tick(4);
    uv_lo = 1'b1;
    tick(10);
    expect_out("R3 low threshold ignored", 1'b0, 1'b1);
    uv_lo = 1'b0;
    tick(3);
    uv_hi = 1'b1;
    tick(UV_WIN - 1);
    uv_hi = 1'b0;
    tick(4);
    expect_out("R3 short dip", 1'b0, 1'b1);
    uv_hi = 1'b1;
    tick(SYNC_STAGES + UV_WIN - 1);
    expect_out("R3 one cycle before window", 1'b0, 1'b1);
    tick(1);
    expect_out("R3 window reached", 1'b1, 1'b0);
    uv_hi = 1'b0;
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear after R3", 1'b0, 1'b0);
    host_pulse();
    expect_out("R4 clear after R3", 1'b0, 1'b1);
    thr_sel = 1'b1;
    tick(4);

    // Over-current during power-up
    seq_idle = 1'b0;
    pwrup_done = 1'b0;
    oc = 1'b1;
    tick(3);
    oc = 1'b0;
    tick(10);
    expect_out("R5 held during power-up", 1'b0, 1'b1);
    pwrup_done = 1'b1;
    tick(1);
    expect_out("R5 R7 acted on at completion", 1'b1, 1'b0);
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear after R5", 1'b0, 1'b0);
    host_pulse();
    expect_out("R4 clear after R5", 1'b0, 1'b1);
    pwrup_done = 1'b0;

    // Held over-current discarded when the sequencer goes idle
    seq_idle = 1'b0;
    oc = 1'b1;
    tick(3);
    oc = 1'b0;
    tick(3);
    seq_idle = 1'b1;
    tick(2);
    seq_idle = 1'b0;
    pwrup_done = 1'b1;
    tick(3);
    expect_out("R5 discarded by idle", 1'b0, 1'b1);

    // Over-current on a powered card, filtered
    oc = 1'b1;
    tick(OC_WIN - 1);
    oc = 1'b0;
    tick(5);
    expect_out("R6 short pulse", 1'b0, 1'b1);
    oc = 1'b1;
    tick(SYNC_STAGES + OC_WIN - 1);
    expect_out("R6 one cycle before window", 1'b0, 1'b1);
    tick(1);
    expect_out("R6 R7 window reached", 1'b1, 1'b0);
    oc = 1'b0;
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear after R6", 1'b0, 1'b0);
    host_pulse();
    expect_out("R4 clear after R6", 1'b0, 1'b1);

    // Card withdrawal: immediate, no flag, single request per assertion
    seq_idle = 1'b0;
    card_out = 1'b1;
    tick(2);
    expect_out("R8 card before latency", 1'b0, 1'b1);
    tick(1);
    expect_out("R8 card request, flag high", 1'b1, 1'b1);
    tick(3);
    expect_out("R8 card held", 1'b1, 1'b1);
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear with card still out", 1'b0, 1'b1);
    tick(4);
    expect_out("R9 no re-request on level", 1'b0, 1'b1);
    card_out = 1'b0;
    tick(3);

    // Over-temperature: immediate, no flag
    seq_idle = 1'b0;
    temp = 1'b1;
    tick(3);
    expect_out("R8 temp request, flag high", 1'b1, 1'b1);
    temp = 1'b0;
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear after temp", 1'b0, 1'b1);

    // New fault in the same cycle as a host rising edge
    seq_idle = 1'b0;
    host_cmd = 1'b0;
    tick(4);
    uv_lo = 1'b1;
    host_cmd = 1'b1;
    tick(3);
    expect_out("R4 new fault beats host edge", 1'b1, 1'b0);
    uv_lo = 1'b0;
    seq_idle = 1'b1;
    tick(1);
    expect_out("R9 clear after collision", 1'b0, 1'b0);
    host_pulse();
    expect_out("R4 clear after collision", 1'b0, 1'b1);

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule